// File: doc/BRIEF.md
# Key-Guarded Indexed Configuration Register Bank

This block holds 256 byte-wide configuration registers behind a two-address window on a simple byte I/O bus. The lower address of the window is the index port. A write there selects a register. The upper address is the data port, which reads or writes the selected register. Reads of either port return data on the same cycle. Any other address on the bus reads as zero.

Data-port writes are guarded by a key. A two-state lock machine starts in `ST_LOCKED`. It takes the `KEY_MATCH` transition to `ST_OPEN` when C5h is written through the data port while the index is 13h. It takes the `KEY_MISS` transition back to `ST_LOCKED` when any other value is written there. All other inputs keep the current state, which is the `HOLD` transition. While the machine is open, a write passes through a per-register filter. The filter drops writes to read-only registers, keeps only the writable bits of masked registers, and merges the upper nibble of register 36h into its old value so that those bits stay set. Bit 1 of register 20h leaves the block as a refresh enable.

Top module: `cfg_idx_regfile`

## Requirements
- R1: A write to the index port (address IDX_PORT, default 22h) loads the index. A read of the index port returns the current index.
- R2: A data-port write at index 13h opens the lock when the value is C5h and closes it for any other value. Nothing is stored at 13h, so it always reads 00h.
- R3: While the lock is closed, data-port writes to any index other than 13h leave every register unchanged.
- R4: Indices 30h, 34h, 35h, 3Eh, 3Fh, 46h, 4Ch, 6Ah and 73h are read-only. Writes to them are ignored even when the lock is open.
- R5: When the lock is open, a write stores the value ANDed with that register's writable mask. The masks are: 12h F7h, 1Eh 07h, 20h BFh, 31h 21h, 32h C1h, 33h FDh, 37h F5h, 3Ch 8Fh, 44h and 45h 3Fh, 4Ah FEh, 55h 03h, 56h C7h, 58h C3h, 59h 60h, 5Bh 1Fh, 64h F7h, 66h E3h, 67h DFh, 69h 50h, 6Bh 7Fh, 6Eh and 6Fh 03h, 71h 1Fh. Every other register stores all 8 bits.
- R6: A write to register 36h ORs the upper nibble of the value into the stored byte. Those bits can then never be cleared by a write, and the lower nibble is never changed by a write.
- R7: Output refresh_en equals bit 1 of register 20h.
- R8: After reset every register is 00h, except these: 11h=F8h, 12h=20h, 17h=FFh, 18h=F0h, 1Ah=FFh, 1Bh=F0h, 1Dh=FFh, 20h=80h, 30h=08h, 31h=01h, 34h=04h, 35h=20h. Register 36h holds strap_id in bit 2 and zeros elsewhere.
- R9: A data-port read returns the register at the current index whether the lock is open or closed. A read of any address outside the window returns 00h.
- R10: Reset is synchronous and active low. It closes the lock and sets the index to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | Bus address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for io_addr, combinational |
| strap_id | input | 1 | Identity strap loaded into bit 2 of register 36h at reset |
| refresh_en | output | 1 | Refresh enable, from bit 1 of register 20h |

## Verification
The bench opens the lock and writes FFh and then 00h to every index, and reads each register back. A design with a wrong mask, a missing read-only entry, or a stored key register shows the wrong byte at that index. It also tries writes with the lock closed, writes with a wrong key after the lock has been opened, and writes of zero to register 36h. A design that ignores the lock, fails to close it on a bad key, or clears the sticky nibble would be seen through data-port reads. Random index, data and key traffic then runs against a reference model, and refresh_en is compared to bit 1 of the model's register 20h after every operation.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int IDX_W      = 8;
    localparam int DATA_W     = 8;
    localparam int DEPTH      = 1 << IDX_W;

    localparam logic [IDX_W-1:0]  KEY_IDX    = 8'h13;
    localparam logic [DATA_W-1:0] KEY_VAL    = 8'hC5;
    localparam logic [IDX_W-1:0]  STICKY_IDX = 8'h36;
    localparam logic [DATA_W-1:0] STICKY_MSK = 8'hF0;
    localparam logic [IDX_W-1:0]  RFSH_IDX   = 8'h20;
    localparam int                RFSH_BIT   = 1;

    typedef enum logic [0:0] {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } lock_state_t;

    function automatic logic is_ro(input logic [IDX_W-1:0] idx);
        case (idx)
            8'h30, 8'h34, 8'h35, 8'h3E, 8'h3F,
            8'h46, 8'h4C, 8'h6A, 8'h73: is_ro = 1'b1;
            default:                    is_ro = 1'b0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] wr_mask(input logic [IDX_W-1:0] idx);
        case (idx)
            8'h12:        wr_mask = 8'hF7;
            8'h1E:        wr_mask = 8'h07;
            8'h20:        wr_mask = 8'hBF;
            8'h31:        wr_mask = 8'h21;
            8'h32:        wr_mask = 8'hC1;
            8'h33:        wr_mask = 8'hFD;
            8'h37:        wr_mask = 8'hF5;
            8'h3C:        wr_mask = 8'h8F;
            8'h44, 8'h45: wr_mask = 8'h3F;
            8'h4A:        wr_mask = 8'hFE;
            8'h55:        wr_mask = 8'h03;
            8'h56:        wr_mask = 8'hC7;
            8'h58:        wr_mask = 8'hC3;
            8'h59:        wr_mask = 8'h60;
            8'h5B:        wr_mask = 8'h1F;
            8'h64:        wr_mask = 8'hF7;
            8'h66:        wr_mask = 8'hE3;
            8'h67:        wr_mask = 8'hDF;
            8'h69:        wr_mask = 8'h50;
            8'h6B:        wr_mask = 8'h7F;
            8'h6E, 8'h6F: wr_mask = 8'h03;
            8'h71:        wr_mask = 8'h1F;
            default:      wr_mask = 8'hFF;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] rst_val(input int idx, input logic strap);
        case (idx)
            'h11:    rst_val = 8'hF8;
            'h12:    rst_val = 8'h20;
            'h17:    rst_val = 8'hFF;
            'h18:    rst_val = 8'hF0;
            'h1A:    rst_val = 8'hFF;
            'h1B:    rst_val = 8'hF0;
            'h1D:    rst_val = 8'hFF;
            'h20:    rst_val = 8'h80;
            'h30:    rst_val = 8'h08;
            'h31:    rst_val = 8'h01;
            'h34:    rst_val = 8'h04;
            'h35:    rst_val = 8'h20;
            'h36:    rst_val = {5'b0, strap, 2'b0};
            default: rst_val = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfg_lock_fsm.sv
module cfg_lock_fsm
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked
);

    lock_state_t state_q, state_d;
    logic        key_slot;

    assign key_slot = data_wr && (idx == KEY_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (key_slot && wdata == KEY_VAL) state_d = ST_OPEN;
            ST_OPEN:   if (key_slot && wdata != KEY_VAL) state_d = ST_LOCKED;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_LOCKED: unlocked = 1'b0;
            ST_OPEN:   unlocked = 1'b1;
        endcase
    end

    AST_KEY_OPEN:  assert property (@(posedge clk) disable iff (!rst_n)
        (key_slot && wdata == KEY_VAL) |=> unlocked);   // R2
    AST_KEY_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (key_slot && wdata != KEY_VAL) |=> !unlocked);  // R2
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !key_slot |=> $stable(unlocked));               // R3

endmodule

// File: rtl/cfg_write_filter.sv
module cfg_write_filter
    import cfg_pkg::*;
(
    input  logic              data_wr,
    input  logic              unlocked,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cur,
    output logic              we,
    output logic [DATA_W-1:0] nv
);

    logic blocked;

    always_comb begin
        blocked = is_ro(idx) || (idx == KEY_IDX) || !unlocked;
        we      = data_wr && !blocked;
        if (idx == STICKY_IDX) nv = cur | (wdata & STICKY_MSK);
        else                   nv = wdata & wr_mask(idx);
    end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] nv,
    output logic [DATA_W-1:0] rd,
    output logic              rfsh
);

    logic [DATA_W-1:0] regs [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)                               regs[i] <= rst_val(i, strap);
            else if (we && idx == IDX_W'(i))          regs[i] <= nv;
        end
    end

    assign rd   = regs[idx];
    assign rfsh = regs[RFSH_IDX][RFSH_BIT];

endmodule

// File: rtl/cfg_idx_regfile.sv
module cfg_idx_regfile
    import cfg_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] IDX_PORT = 16'h0022
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              strap_id,
    output logic              refresh_en
);

    localparam logic [ADDR_W-1:0] DATA_PORT = IDX_PORT + ADDR_W'(1);

    logic [IDX_W-1:0]  idx_q;
    logic              hit_idx, hit_data, idx_wr, data_wr;
    logic              unlocked, we;
    logic [DATA_W-1:0] cur, nv;

    assign hit_idx  = (io_addr == IDX_PORT);
    assign hit_data = (io_addr == DATA_PORT);
    assign idx_wr   = io_wr && hit_idx;
    assign data_wr  = io_wr && hit_data;

    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_wr) idx_q <= io_wdata;
    end

    cfg_lock_fsm u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_wr  (data_wr),
        .idx      (idx_q),
        .wdata    (io_wdata),
        .unlocked (unlocked)
    );

    cfg_write_filter u_filt (
        .data_wr  (data_wr),
        .unlocked (unlocked),
        .idx      (idx_q),
        .wdata    (io_wdata),
        .cur      (cur),
        .we       (we),
        .nv       (nv)
    );

    cfg_reg_bank u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .strap (strap_id),
        .we    (we),
        .idx   (idx_q),
        .nv    (nv),
        .rd    (cur),
        .rfsh  (refresh_en)
    );

    always_comb begin
        if (hit_idx)       io_rdata = idx_q;
        else if (hit_data) io_rdata = cur;
        else               io_rdata = '0;
    end

    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (idx_q == $past(io_wdata)));                               // R1
    AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !unlocked) |=> $stable(cur));                             // R3
    AST_RO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && is_ro(idx_q)) |=> $stable(cur));                          // R4
    AST_MASKED_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && unlocked && !is_ro(idx_q) && idx_q != KEY_IDX && idx_q != STICKY_IDX)
        |=> (cur == ($past(io_wdata) & wr_mask(idx_q))));                     // R5
    AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && idx_q == STICKY_IDX) |=> ((cur & $past(cur)) == $past(cur))); // R6
    AST_KEY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q == KEY_IDX) |-> (cur == '0));                                  // R2

endmodule

// File: tb/tb_cfg_idx_regfile.sv
`timescale 1ns/1ps
module tb_cfg_idx_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic        strap_id = 1'b1;
    logic        refresh_en;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [7:0] mdl [256];
    logic [7:0] m_idx;
    bit         m_open;

    always #2 clk = ~clk;

    cfg_idx_regfile dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .strap_id(strap_id),
        .refresh_en(refresh_en)
    );

    function automatic bit ro_f(input logic [7:0] i);
        return (i == 8'h30 || i == 8'h34 || i == 8'h35 || i == 8'h3E || i == 8'h3F ||
                i == 8'h46 || i == 8'h4C || i == 8'h6A || i == 8'h73);
    endfunction

    function automatic logic [7:0] mask_f(input logic [7:0] i);
        case (i)
            8'h12: return 8'hF7;  8'h1E: return 8'h07;  8'h20: return 8'hBF;
            8'h31: return 8'h21;  8'h32: return 8'hC1;  8'h33: return 8'hFD;
            8'h37: return 8'hF5;  8'h3C: return 8'h8F;  8'h44: return 8'h3F;
            8'h45: return 8'h3F;  8'h4A: return 8'hFE;  8'h55: return 8'h03;
            8'h56: return 8'hC7;  8'h58: return 8'hC3;  8'h59: return 8'h60;
            8'h5B: return 8'h1F;  8'h64: return 8'hF7;  8'h66: return 8'hE3;
            8'h67: return 8'hDF;  8'h69: return 8'h50;  8'h6B: return 8'h7F;
            8'h6E: return 8'h03;  8'h6F: return 8'h03;  8'h71: return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
        mdl[8'h11] = 8'hF8; mdl[8'h12] = 8'h20; mdl[8'h17] = 8'hFF;
        mdl[8'h18] = 8'hF0; mdl[8'h1A] = 8'hFF; mdl[8'h1B] = 8'hF0;
        mdl[8'h1D] = 8'hFF; mdl[8'h20] = 8'h80; mdl[8'h30] = 8'h08;
        mdl[8'h31] = 8'h01; mdl[8'h34] = 8'h04; mdl[8'h35] = 8'h20;
        mdl[8'h36] = {5'b0, strap_id, 2'b0};
        m_idx = 8'h00;
        m_open = 0;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        if (a == 16'h22) m_idx = d;
        else if (a == 16'h23) begin
            if (m_idx == 8'h13) m_open = (d == 8'hC5);
            else if (m_open && !ro_f(m_idx)) begin
                if (m_idx == 8'h36) mdl[m_idx] = mdl[m_idx] | (d & 8'hF0);
                else                mdl[m_idx] = d & mask_f(m_idx);
            end
        end
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wr = 1'b0;
        #1;
        d = io_rdata;
    endtask

    task automatic check_reg(input string req, input logic [7:0] i);
        logic [7:0] v;
        bus_wr(16'h22, i);
        bus_rd(16'h23, v);
        chk(req, v, mdl[i]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20417));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: index 00 after reset
        bus_rd(16'h22, v);
        chk("R10 index reset", v, 8'h00);
        // R7: refresh_en from reset value of 20h
        chk("R7 refresh after reset", {7'b0, refresh_en}, {7'b0, mdl[8'h20][1]});
        // R8: reset contents of every register
        for (int i = 0; i < 256; i++) check_reg("R8 reset value", 8'(i));
        // R9: address outside the window reads zero
        bus_rd(16'h0024, v); chk("R9 outside window", v, 8'h00);
        bus_rd(16'h0021, v); chk("R9 outside window", v, 8'h00);

        // R3 / R10: locked after reset, writes dropped
        bus_wr(16'h22, 8'h20); bus_wr(16'h23, 8'h02);
        check_reg("R3 locked write dropped", 8'h20);
        chk("R7 refresh locked", {7'b0, refresh_en}, 8'h00);
        bus_wr(16'h22, 8'h50); bus_wr(16'h23, 8'hA5);
        check_reg("R3 locked write dropped", 8'h50);

        // R2: open with key
        bus_wr(16'h22, 8'h13); bus_wr(16'h23, 8'hC5);
        check_reg("R2 key register empty", 8'h13);
        // R5 / R4: FF then 00 to every index
        for (int i = 0; i < 256; i++) begin
            if (i != 'h13) begin
                bus_wr(16'h22, 8'(i)); bus_wr(16'h23, 8'hFF);
                bus_rd(16'h23, v); chk("R5 R4 write FF", v, mdl[i]);
            end
        end
        chk("R7 refresh set", {7'b0, refresh_en}, 8'h01);
        for (int i = 0; i < 256; i++) begin
            if (i != 'h13) begin
                bus_wr(16'h22, 8'(i)); bus_wr(16'h23, 8'h00);
                bus_rd(16'h23, v); chk("R5 R4 R6 write 00", v, mdl[i]);
            end
        end
        chk("R7 refresh clear", {7'b0, refresh_en}, 8'h00);
        // R6: sticky nibble kept, strap bit kept
        check_reg("R6 sticky 36h", 8'h36);
        chk("R6 sticky expected", mdl[8'h36], 8'hF4);

        // R2: bad key closes, then writes dropped
        bus_wr(16'h22, 8'h13); bus_wr(16'h23, 8'hC4);
        bus_wr(16'h22, 8'h40); bus_wr(16'h23, 8'h77);
        check_reg("R2 bad key relocks", 8'h40);
        // R1: index readback
        bus_wr(16'h22, 8'h9C); bus_rd(16'h22, v);
        chk("R1 index readback", v, 8'h9C);
        // R9: read while locked
        bus_rd(16'h23, v); chk("R9 locked read", v, mdl[8'h9C]);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [7:0] d, i;
            op = $urandom_range(0, 9);
            d  = 8'($urandom);
            if ($urandom_range(0, 1) == 0) begin
                case ($urandom_range(0, 5))
                    0: i = 8'h13; 1: i = 8'h36; 2: i = 8'h20;
                    3: i = 8'h30; 4: i = 8'h59; default: i = 8'h12;
                endcase
            end else i = 8'($urandom);
            case (op)
                0, 1:    bus_wr(16'h22, i);
                2:       begin bus_wr(16'h22, 8'h13); bus_wr(16'h23, ($urandom_range(0,3) != 0) ? 8'hC5 : d); end
                3, 4, 5: bus_wr(16'h23, d);
                6:       begin bus_rd(16'h22, v); chk("R1 random index", v, m_idx); end
                7:       begin bus_rd(16'h23, v); chk("R9 R5 random data", v, mdl[m_idx]); end
                default: check_reg("R3 R4 R5 R6 random reg", i);
            endcase
            chk("R7 random refresh", {7'b0, refresh_en}, {7'b0, mdl[8'h20][1]});
        end

        // R10: reset mid-run closes lock and clears index
        bus_wr(16'h22, 8'h13); bus_wr(16'h23, 8'hC5);
        @(negedge clk); rst_n = 1'b0; strap_id = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_reset();
        bus_rd(16'h22, v); chk("R10 index after reset", v, 8'h00);
        check_reg("R8 strap low", 8'h36);
        bus_wr(16'h22, 8'h61); bus_wr(16'h23, 8'h3C);
        check_reg("R10 locked after reset", 8'h61);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule